// File: doc/BRIEF.md
# I2C Controller Bring-Up and Stuck-Bus Recovery Sequencer

This block sits beside an I2C byte engine and drives that engine's register port to bring the controller out of reset. When `start` is pulsed, it turns the engine off and waits a short settling time. It then loads the clock divider, the input filter setting and the controller's own slave address, clears the status register and enables the engine. After that it reads the status register on every cycle while the bus reports busy. If the bus goes idle inside the timeout window, the sequence ends there.

If the bus still reports busy when the window closes, the block runs a recovery pass. It claims the bus as master and waits for the busy flag to assert. If arbitration was lost at that point, it treats SDA as held low and pulses the control bits with a timed pause between them. It then performs a throw-away data read and waits for the byte-complete interrupt flag. Both waits are bounded by the same window. Every exit from recovery leaves the engine enabled, clears the status register and pauses before reporting completion.

All delays are whole microseconds, derived from a prescaler of `TICKS_PER_US` clock cycles. The configuration inputs are captured when a start is accepted. The register port is a plain strobe interface: the engine must answer a read with `reg_rdata` in the same cycle and must accept a write in the cycle it is issued. It never stalls the sequencer.

Top module: `i2c_bus_bringup`

## Requirements
- R1: After reset and whenever idle, `busy`, `done` and `fail` are low and neither `reg_wr` nor `reg_rd` is asserted.
- R2: A `start` pulse is accepted only while `busy` is low. A `start` during a run has no effect on the access sequence or on the number of `done` pulses. `cfg_div`, `cfg_filt`, `cfg_own` and `errata_en` are sampled only when a start is accepted.
- R3: Register addresses are: control 0, status 1, data 2, own address 3, divider 4, filter 5. The first access of a run writes control = 0x00. SETTLE_US later, the following writes occur on consecutive cycles: divider, filter, own address = {cfg_own, 1'b0}, status = 0x00, control = 0x80 (bit 7 is enable). Any access that follows a delay of N µs is issued exactly N*TICKS_PER_US+1 cycles after the access before the delay.
- R4: Starting in the cycle after the enable write, status is read on every cycle, for at most W = TIMEOUT_US*TICKS_PER_US reads. Bit 5 is bus-busy. The first read with bit 5 clear ends the run, with `done` high in the next cycle and no further access.
- R5: If all W reads show bus-busy, the next cycle writes control = 0xA0 (enable plus master-start, bit 5), with no errata bit. Status is then read each cycle, for at most W reads, until bit 5 is set. The cycle after that, one further status read samples arbitration-lost (bit 4).
- R6: If arbitration-lost is set, the sequencer writes control = 0x00. HOLD_US later it writes control = 0x20|F, and in the next cycle control = 0xA0|F.
- R7: In the cycle after the arbitration check (R5), or after the last write of R6 when that branch is taken, data is read once and discarded. Status is then read each cycle, for at most W reads, until interrupt bit 1 is set.
- R8: The exit writes control = 0x80|F, then status = 0x00 in the next cycle. `done` rises HOLD_US after the status write.
- R9: If the bus-busy wait of R5 times out, the arbitration check and the data read are skipped and the exit of R8 follows in the next cycle.
- R10: `fail` is updated together with `done`. It is high only if the wait of R5 or R7 timed out, and it returns low when the next start is accepted.
- R11: F is 0x40 (bit 6) when the captured `errata_en` is high and 0x00 otherwise. It appears only in the R6 writes 0x20|F and 0xA0|F and in the exit write 0x80|F.
- R12: `done` is a single-cycle pulse that is asserted only when a run finishes. `reg_wr` and `reg_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (accepted when idle) |
| cfg_div | input | 8 | Divider value to load |
| cfg_filt | input | 8 | Filter value to load |
| cfg_own | input | 7 | Own 7-bit slave address |
| errata_en | input | 1 | Add the errata bit to recovery control writes |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 3 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the cycle of `reg_rd` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| fail | output | 1 | A recovery wait expired in the last run |

## Verification
Two decisions can land in the same cycle: the window timing out, and a status read that satisfies the wait. Both the free-bus wait and the interrupt wait are driven with the bus model answering on read W-1, the last read of the window, and on read W, one read too late. In the first case the satisfying read must win, with no recovery and no fail. In the second case the bench expects the timeout path, checked by the exact cycle offsets of the writes that follow. The sweep also crosses the arbitration-lost branch with the errata flag, so that flagged and unflagged control writes are checked in both recovery paths.

// File: rtl/i2c_bringup_pkg.sv
package i2c_bringup_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] RA_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] RA_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] RA_OWN  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_DIV  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_FILT = 3'd5;

  // control bit positions
  localparam int CB_EN   = 7;
  localparam int CB_FLAG = 6;
  localparam int CB_MSTA = 5;
  // status bit positions
  localparam int SB_BUSY = 5;
  localparam int SB_ARB  = 4;
  localparam int SB_IRQ  = 1;

  localparam logic [REG_W-1:0] CV_EN   = REG_W'(1) << CB_EN;
  localparam logic [REG_W-1:0] CV_FLAG = REG_W'(1) << CB_FLAG;
  localparam logic [REG_W-1:0] CV_MSTA = REG_W'(1) << CB_MSTA;
  localparam logic [REG_W-1:0] SV_USED = (REG_W'(1) << SB_BUSY) |
                                         (REG_W'(1) << SB_ARB) |
                                         (REG_W'(1) << SB_IRQ);

  typedef enum logic [3:0] {
    OP_NONE, OP_CTRL_OFF, OP_DIV, OP_FILT, OP_OWN, OP_STAT_CLR,
    OP_CTRL_ON, OP_RD_STAT, OP_CTRL_GRAB, OP_CTRL_MS_F,
    OP_CTRL_GRAB_F, OP_RD_DATA, OP_CTRL_ON_F
  } op_e;

  typedef enum logic [4:0] {
    S_IDLE, S_OFF, S_SETTLE, S_DIV, S_FILT, S_OWN, S_CLRST, S_ON,
    S_POLLFREE, S_GRAB, S_POLLBB, S_CHKARB, S_STK_OFF, S_STK_WAIT,
    S_STK_MS, S_STK_GRAB, S_DUMMY, S_POLLIF, S_X_ON, S_X_CLR, S_X_WAIT
  } st_e;
endpackage

// File: rtl/i2c_us_timer.sv
module i2c_us_timer #(
  parameter int TICKS_PER_US = 100,
  parameter int UW           = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic          us_wrap,
  output logic [UW-1:0] us_cnt
);
  localparam int TW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

  logic [TW-1:0] tick_cnt;

  assign us_wrap = (tick_cnt == TW'(TICKS_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      us_cnt   <= '0;
    end else if (clr) begin
      tick_cnt <= '0;
      us_cnt   <= '0;
    end else if (us_wrap) begin
      tick_cnt <= '0;
      us_cnt   <= us_cnt + UW'(1);
    end else begin
      tick_cnt <= tick_cnt + TW'(1);
    end
  end
endmodule

// File: rtl/i2c_bringup_fsm.sv
module i2c_bringup_fsm
  import i2c_bringup_pkg::*;
#(
  parameter int SETTLE_US  = 5,
  parameter int HOLD_US    = 100,
  parameter int TIMEOUT_US = 100000,
  parameter int UW         = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          st_busy,
  input  logic          st_arb,
  input  logic          st_irq,
  input  logic          us_wrap,
  input  logic [UW-1:0] us_cnt,
  output op_e           op,
  output logic          tmr_clr,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  st_e  st, nxt;
  logic go, finish, set_fail, fail_pend;
  logic exp_settle, exp_hold, exp_window;

  assign go         = start && (st == S_IDLE);
  assign exp_settle = us_wrap && (us_cnt == UW'(SETTLE_US - 1));
  assign exp_hold   = us_wrap && (us_cnt == UW'(HOLD_US - 1));
  assign exp_window = us_wrap && (us_cnt == UW'(TIMEOUT_US - 1));

  always_comb begin
    nxt      = st;
    op       = OP_NONE;
    finish   = 1'b0;
    set_fail = 1'b0;
    case (st)
      S_IDLE:     if (go) nxt = S_OFF;
      S_OFF:      begin op = OP_CTRL_OFF; nxt = S_SETTLE; end
      S_SETTLE:   if (exp_settle) nxt = S_DIV;
      S_DIV:      begin op = OP_DIV;  nxt = S_FILT; end
      S_FILT:     begin op = OP_FILT; nxt = S_OWN; end
      S_OWN:      begin op = OP_OWN;  nxt = S_CLRST; end
      S_CLRST:    begin op = OP_STAT_CLR; nxt = S_ON; end
      S_ON:       begin op = OP_CTRL_ON;  nxt = S_POLLFREE; end
      S_POLLFREE: begin
        op = OP_RD_STAT;
        if (!st_busy) begin nxt = S_IDLE; finish = 1'b1; end
        else if (exp_window) nxt = S_GRAB;
      end
      S_GRAB:     begin op = OP_CTRL_GRAB; nxt = S_POLLBB; end
      S_POLLBB:   begin
        op = OP_RD_STAT;
        if (st_busy) nxt = S_CHKARB;
        else if (exp_window) begin set_fail = 1'b1; nxt = S_X_ON; end
      end
      S_CHKARB:   begin op = OP_RD_STAT; nxt = st_arb ? S_STK_OFF : S_DUMMY; end
      S_STK_OFF:  begin op = OP_CTRL_OFF; nxt = S_STK_WAIT; end
      S_STK_WAIT: if (exp_hold) nxt = S_STK_MS;
      S_STK_MS:   begin op = OP_CTRL_MS_F;   nxt = S_STK_GRAB; end
      S_STK_GRAB: begin op = OP_CTRL_GRAB_F; nxt = S_DUMMY; end
      S_DUMMY:    begin op = OP_RD_DATA; nxt = S_POLLIF; end
      S_POLLIF:   begin
        op = OP_RD_STAT;
        if (st_irq) nxt = S_X_ON;
        else if (exp_window) begin set_fail = 1'b1; nxt = S_X_ON; end
      end
      S_X_ON:     begin op = OP_CTRL_ON_F; nxt = S_X_CLR; end
      S_X_CLR:    begin op = OP_STAT_CLR;  nxt = S_X_WAIT; end
      S_X_WAIT:   if (exp_hold) begin nxt = S_IDLE; finish = 1'b1; end
      default:    nxt = S_IDLE;
    endcase
  end

  assign tmr_clr = (nxt != st);
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_pend <= 1'b0;
    end else begin
      st   <= nxt;
      done <= finish;
      if (go) fail_pend <= 1'b0;
      else if (set_fail) fail_pend <= 1'b1;
      if (go) fail <= 1'b0;
      else if (finish) fail <= fail_pend;
    end
  end
endmodule

// File: rtl/i2c_bringup_regport.sv
module i2c_bringup_regport
  import i2c_bringup_pkg::*;
(
  input  op_e               op,
  input  logic [REG_W-1:0]  div,
  input  logic [REG_W-1:0]  filt,
  input  logic [REG_W-2:0]  own,
  input  logic              errata,
  output logic              wr,
  output logic              rd,
  output logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  wdata
);
  logic [REG_W-1:0] flag;

  assign flag = errata ? CV_FLAG : '0;

  always_comb begin
    wr    = 1'b0;
    rd    = 1'b0;
    addr  = RA_CTRL;
    wdata = '0;
    case (op)
      OP_CTRL_OFF:    wr = 1'b1;
      OP_DIV:         begin wr = 1'b1; addr = RA_DIV;  wdata = div; end
      OP_FILT:        begin wr = 1'b1; addr = RA_FILT; wdata = filt; end
      OP_OWN:         begin wr = 1'b1; addr = RA_OWN;  wdata = {own, 1'b0}; end
      OP_STAT_CLR:    begin wr = 1'b1; addr = RA_STAT; end
      OP_CTRL_ON:     begin wr = 1'b1; wdata = CV_EN; end
      OP_RD_STAT:     begin rd = 1'b1; addr = RA_STAT; end
      OP_CTRL_GRAB:   begin wr = 1'b1; wdata = CV_EN | CV_MSTA; end
      OP_CTRL_MS_F:   begin wr = 1'b1; wdata = CV_MSTA | flag; end
      OP_CTRL_GRAB_F: begin wr = 1'b1; wdata = CV_EN | CV_MSTA | flag; end
      OP_RD_DATA:     begin rd = 1'b1; addr = RA_DATA; end
      OP_CTRL_ON_F:   begin wr = 1'b1; wdata = CV_EN | flag; end
      default:        ;
    endcase
  end
endmodule

// File: rtl/i2c_bus_bringup.sv
module i2c_bus_bringup
  import i2c_bringup_pkg::*;
#(
  parameter int TICKS_PER_US = 100,
  parameter int SETTLE_US    = 5,
  parameter int HOLD_US      = 100,
  parameter int TIMEOUT_US   = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REG_W-1:0] cfg_div,
  input  logic [REG_W-1:0] cfg_filt,
  input  logic [REG_W-2:0] cfg_own,
  input  logic             errata_en,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [REG_W-1:0] reg_wdata,
  input  logic [REG_W-1:0] reg_rdata,
  output logic             busy,
  output logic             done,
  output logic             fail
);
  localparam int MAX_US = (TIMEOUT_US > HOLD_US) ?
                          ((TIMEOUT_US > SETTLE_US) ? TIMEOUT_US : SETTLE_US) :
                          ((HOLD_US > SETTLE_US) ? HOLD_US : SETTLE_US);
  localparam int UW = $clog2(MAX_US + 1);

  logic [REG_W-1:0] cap_div, cap_filt;
  logic [REG_W-2:0] cap_own;
  logic             cap_err;
  logic             accept, tmr_clr, us_wrap;
  logic [UW-1:0]    us_cnt;
  op_e              op;
  logic             unused_rdata;

  assign accept       = start && !busy;
  assign unused_rdata = ^(reg_rdata & ~SV_USED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_div  <= '0;
      cap_filt <= '0;
      cap_own  <= '0;
      cap_err  <= 1'b0;
    end else if (accept) begin
      cap_div  <= cfg_div;
      cap_filt <= cfg_filt;
      cap_own  <= cfg_own;
      cap_err  <= errata_en;
    end
  end

  i2c_us_timer #(.TICKS_PER_US(TICKS_PER_US), .UW(UW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .us_wrap(us_wrap), .us_cnt(us_cnt)
  );

  i2c_bringup_fsm #(
    .SETTLE_US(SETTLE_US), .HOLD_US(HOLD_US), .TIMEOUT_US(TIMEOUT_US), .UW(UW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .st_busy(reg_rdata[SB_BUSY]), .st_arb(reg_rdata[SB_ARB]),
    .st_irq(reg_rdata[SB_IRQ]), .us_wrap(us_wrap), .us_cnt(us_cnt),
    .op(op), .tmr_clr(tmr_clr), .busy(busy), .done(done), .fail(fail)
  );

  i2c_bringup_regport u_port (
    .op(op), .div(cap_div), .filt(cap_filt), .own(cap_own), .errata(cap_err),
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata)
  );
endmodule

// File: rtl/i2c_bringup_chk.sv
module i2c_bringup_chk
  import i2c_bringup_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              busy,
  input logic              done,
  input logic              fail
);
  // R1
  acc_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> busy);
  // R12
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  // R3
  own_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_OWN) |-> !reg_wdata[0]);
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R10
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);
endmodule

bind i2c_bus_bringup i2c_bringup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy), .done(done),
  .fail(fail)
);

// File: tb/tb_i2c_bus_bringup.sv
module tb_i2c_bus_bringup;
  localparam int TPU = 2, SET = 2, HLD = 3, TMO = 4;
  localparam int W = TMO * TPU, SD = SET * TPU, HD = HLD * TPU;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, errata_en = 1'b0;
  logic [7:0] cfg_div = '0, cfg_filt = '0;
  logic [6:0] cfg_own = '0;
  logic reg_wr, reg_rd, busy, done, fail;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  i2c_bus_bringup #(.TICKS_PER_US(TPU), .SETTLE_US(SET), .HOLD_US(HLD),
                    .TIMEOUT_US(TMO)) dut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus/engine model: knobs set by the stimulus before each run
  int k_free = 0, k_bb = 0, k_ifa = 0;
  bit k_al = 0;
  int phase = 0, rcnt = 0;
  always_comb begin
    reg_rdata = '0;
    case (phase)
      1: reg_rdata[5] = (rcnt < k_free);
      2: begin reg_rdata[5] = (rcnt >= k_bb); reg_rdata[4] = k_al; end
      3: begin reg_rdata[5] = 1'b1; reg_rdata[1] = (rcnt >= k_ifa); end
      default: ;
    endcase
  end
  always @(posedge clk) begin
    if (reg_wr && reg_addr == 3'd0 && reg_wdata == 8'h00) begin phase <= 0; rcnt <= 0; end
    else if (reg_wr && reg_addr == 3'd0 && reg_wdata == 8'h80) begin phase <= 1; rcnt <= 0; end
    else if (reg_wr && reg_addr == 3'd0 && reg_wdata == 8'hA0) begin phase <= 2; rcnt <= 0; end
    else if (reg_rd && reg_addr == 3'd2) begin phase <= 3; rcnt <= 0; end
    else if (reg_rd && reg_addr == 3'd1) rcnt <= rcnt + 1;
  end

  int n_chk = 0, n_fail = 0;
  int wa[32], wd[32], wc[32], nw, nsr, ndr, drc, ndone, donec, dfail, idle_acc;
  int ea[16], ed[16], eo[16], ne;
  string et[16];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input int a, input int d, input int o, input string t);
    ea[ne] = a; ed[ne] = d; eo[ne] = o; et[ne] = t; ne++;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic run(input int fa, input int bb, input bit al, input int ifa,
                     input bit er, input bit restart, input logic [7:0] dv,
                     input logic [7:0] fi, input logic [6:0] ow);
    int t, td, efail, esr, edr, edone, it, after;
    k_free = fa; k_bb = bb; k_al = al; k_ifa = ifa;
    cfg_div = dv; cfg_filt = fi; cfg_own = ow; errata_en = er;
    nw = 0; nsr = 0; ndr = 0; drc = -1; ndone = 0; donec = -1; dfail = 0;
    start = 1'b1;
    it = 0; after = -1;
    while (after != 0) begin
      @(negedge clk);
      it++;
      start = 1'b0;
      if (restart && it == 3) begin
        start = 1'b1; cfg_div = ~dv; cfg_filt = ~fi; cfg_own = ~ow; errata_en = !er;
      end
      if (reg_wr && nw < 32) begin wa[nw] = reg_addr; wd[nw] = reg_wdata; wc[nw] = cyc; nw++; end
      if (reg_rd && reg_addr == 3'd1) nsr++;
      if (reg_rd && reg_addr == 3'd2) begin ndr++; drc = cyc; end
      if (done) begin ndone++; if (donec < 0) begin donec = cyc; dfail = fail; end end
      if (ndone > 0 && after < 0) after = 3;
      else if (after > 0) after--;
      if (it > 400) begin
        check(1'b0, "watchdog", it, 400);
        finish_run();
      end
    end
    // expected sequence, offsets relative to the first write
    ne = 0;
    push(0, 0, 0, "R3"); push(4, dv, SD + 1, "R3"); push(5, fi, SD + 2, "R3");
    push(3, {ow, 1'b0}, SD + 3, "R3"); push(1, 0, SD + 4, "R3");
    push(0, 8'h80, SD + 5, "R3");
    t = SD + 5; efail = 0; edr = 0; td = -1;
    if (fa < W) begin
      esr = fa + 1; edone = t + fa + 2;
    end else begin
      esr = W; t = t + W + 1; push(0, 8'hA0, t, "R5");
      if (bb < W) begin
        esr += bb + 2;
        if (al) begin
          t = t + bb + 3; push(0, 0, t, "R6");
          t = t + HD + 1; push(0, 8'h20 | (er ? 8'h40 : 0), t, er ? "R11" : "R6");
          t = t + 1;      push(0, 8'hA0 | (er ? 8'h40 : 0), t, er ? "R11" : "R6");
          td = t + 1;
        end else td = t + bb + 3;
        edr = 1;
        if (ifa < W) begin esr += ifa + 1; t = td + ifa + 2; end
        else begin esr += W; t = td + W + 1; efail = 1; end
      end else begin
        esr += W; t = t + W + 1; efail = 1;
      end
      push(0, 8'h80 | (er ? 8'h40 : 0), t, er ? "R11" : "R8");
      t = t + 1; push(1, 0, t, "R8");
      edone = t + HD + 1;
    end
    check(nw == ne, (bb >= W && fa >= W) ? "R9 write count" : "R3 write count", nw, ne);
    for (int i = 0; i < ne && i < nw; i++) begin
      check(wa[i] == ea[i], {et[i], " addr"}, wa[i], ea[i]);
      check(wd[i] == ed[i], {et[i], " data"}, wd[i], ed[i]);
      check(wc[i] - wc[0] == eo[i], {et[i], " cycle"}, wc[i] - wc[0], eo[i]);
    end
    check(nsr == esr, "R4 status reads", nsr, esr);
    check(ndr == edr, (bb >= W) ? "R9 no data read" : "R7 data reads", ndr, edr);
    if (edr == 1) check(drc - wc[0] == td, "R7 data read cycle", drc - wc[0], td);
    check(ndone == 1, "R12 done pulses", ndone, 1);
    check(donec - wc[0] == edone, "R8 done cycle", donec - wc[0], edone);
    check(dfail == efail, "R10 fail", dfail, efail);
    check(!busy && !reg_wr && !reg_rd, "R1 idle after run", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !fail && !reg_wr && !reg_rd, "R1 reset", {busy, done, fail}, 0);
    rst_n = 1'b1;
    idle_acc = 0;
    repeat (5) begin @(negedge clk); if (reg_wr || reg_rd || busy) idle_acc++; end
    check(idle_acc == 0, "R1 idle quiet", idle_acc, 0);
    // R4 free-bus sweep across the window edge (W-1 wins, W times out)
    for (int fa = 0; fa <= W + 1; fa++)
      run(fa, 0, 0, 0, 0, 0, 8'h3C + fa, 8'h11, 7'h50 + fa);
    // R2 restart during a run with changed configuration
    run(3, 0, 0, 0, 0, 1, 8'hA5, 8'h5A, 7'h2B);
    // R5..R11 recovery sweep
    for (int b = 0; b < 3; b++)
      for (int a = 0; a < 2; a++)
        for (int f = 0; f < 3; f++)
          for (int e = 0; e < 2; e++)
            run(W, (b == 0) ? 0 : W - 2 + b, a[0], (f == 0) ? 0 : W - 2 + f, e[0], 0,
                8'h20 + b, 8'h40 + f, 7'h11 * (a + 1));
    // R10 fail clears on the next accepted start
    run(0, 0, 0, 0, 0, 0, 8'h01, 8'h02, 7'h03);
    finish_run();
  end
endmodule